// File: doc/BRIEF.md
# Memory March Test Sequencer

This block is a built-in self-test engine for a synchronous single-port memory. After a start pulse it takes over the memory's enable, write enable, address and write data lines. It runs one of three test algorithms and checks every word read back against the value it expects. When the run is over it reports pass or fail, and on a failure it gives the address of the first word that did not match.

The algorithms are a checkerboard test, a seven-element march and a solid-pattern test. The checkerboard test writes the pattern, reads it back, then does the same with the inverted pattern. The march test uses single and double read/complement-write pairs in both address directions. The solid test uses all zeros and then all ones. The memory returns read data a fixed number of cycles (`RD_LAT`) after the request. The engine carries the expected word and the address along with each read through a matching delay line. Memory depth, data width and read latency are parameters.

Top module: `mbist_march`

## Requirements
- R1: After reset, busy, done, pass, mem_en and mem_we are all low.
- R2: A start is accepted only while busy is low. A start pulse or an algo_sel change during a run has no effect: the operation stream and its single done are unchanged.
- R3: algo_sel=0 runs the checkerboard test. It writes every address in ascending order, reads them all in ascending order, then writes and reads the inverted pattern the same way. The word bit i is set when (i odd) XOR (address bit 0), so with 8 data bits even addresses get 0xAA and odd addresses 0x55; the inverted phase swaps these.
- R4: algo_sel=1 runs the march test, one operation per address in each element.
  1. Ascending: write 0.
  2. Ascending: read, write complement.
  3. Ascending: read.
  4. Ascending: read, write complement, read, write complement.
  5. Descending: read, write complement.
  6. Descending: read, write complement, read, write complement.
  7. Descending: read.
- R5: algo_sel=2 and algo_sel=3 run the solid test. It writes all zeros in ascending order, reads them all in ascending order, then writes and reads all ones the same way.
- R6: A read checks the memory word RD_LAT cycles after the request against the word last written to that address. On a fault-free memory the run ends with pass high.
- R7: The first mismatching read latches its address on fail_addr. Later mismatches leave fail_addr unchanged until the next accepted start.
- R8: After a mismatch the sequence still runs to its last operation before done rises, and pass stays low.
- R9: Done rises only once the last read has been compared. It then stays high, with busy low, until the next accepted start. pass and fail_addr are valid while done is high.
- R10: mem_en is high for exactly one cycle per operation, and mem_we is high only on writes. Both are low outside a run.
- R11: A mismatch on the final read of a run is still reported when done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled while idle |
| algo_sel | input | 2 | Algorithm: 0 checkerboard, 1 march, 2 or 3 solid |
| mem_en | output | 1 | Memory operation enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | $clog2(DEPTH) | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, RD_LAT cycles after the request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| pass | output | 1 | High with done when no read mismatched |
| fail_addr | output | $clog2(DEPTH) | Address of the first mismatching read |

## Verification
The result of the last comparison and the end of the drain phase can fall in the same cycle. If the drain ends before that comparison is counted, done rises with a stale pass. This is provoked in the solid test by a stuck-at-zero bit on the highest address. The fault shows only on the all-ones read of that address, which is the very last read of the run. The run is judged by requiring pass low and fail_addr equal to that address once done rises. A second case uses two faulty addresses, where the higher address fails first in time, to judge that the first mismatch is kept rather than the last.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef logic [1:0] op_t;

  localparam op_t OP_RD = 2'd0;  // read and compare against current background
  localparam op_t OP_WC = 2'd1;  // write complement of current background
  localparam op_t OP_W0 = 2'd2;  // write background polarity 0
  localparam op_t OP_W1 = 2'd3;  // write background polarity 1

  localparam logic [1:0] ALG_CHECKER = 2'd0;
  localparam logic [1:0] ALG_MARCH   = 2'd1;

  typedef struct packed {
    logic            fin;      // final element of the algorithm
    logic            down;     // descending address order
    logic [1:0]      last_op;  // index of the last operation per address
    op_t  [3:0]      ops;      // ops[0] is issued first
  } elem_t;

  function automatic elem_t mk_elem(input logic fin, input logic down,
                                    input logic [1:0] last_op,
                                    input op_t o0, input op_t o1,
                                    input op_t o2, input op_t o3);
    elem_t e;
    e.fin     = fin;
    e.down    = down;
    e.last_op = last_op;
    e.ops[0]  = o0;
    e.ops[1]  = o1;
    e.ops[2]  = o2;
    e.ops[3]  = o3;
    return e;
  endfunction

  function automatic elem_t elem_lookup(input logic [1:0] alg, input logic [2:0] idx);
    elem_t e;
    if (alg == ALG_MARCH) begin
      case (idx)
        3'd0:    e = mk_elem(1'b0, 1'b0, 2'd0, OP_W0, OP_RD, OP_RD, OP_RD);
        3'd1:    e = mk_elem(1'b0, 1'b0, 2'd1, OP_RD, OP_WC, OP_RD, OP_RD);
        3'd2:    e = mk_elem(1'b0, 1'b0, 2'd0, OP_RD, OP_RD, OP_RD, OP_RD);
        3'd3:    e = mk_elem(1'b0, 1'b0, 2'd3, OP_RD, OP_WC, OP_RD, OP_WC);
        3'd4:    e = mk_elem(1'b0, 1'b1, 2'd1, OP_RD, OP_WC, OP_RD, OP_RD);
        3'd5:    e = mk_elem(1'b0, 1'b1, 2'd3, OP_RD, OP_WC, OP_RD, OP_WC);
        default: e = mk_elem(1'b1, 1'b1, 2'd0, OP_RD, OP_RD, OP_RD, OP_RD);
      endcase
    end else begin
      // checkerboard and solid share one element list; only the pattern differs
      case (idx)
        3'd0:    e = mk_elem(1'b0, 1'b0, 2'd0, OP_W0, OP_RD, OP_RD, OP_RD);
        3'd1:    e = mk_elem(1'b0, 1'b0, 2'd0, OP_RD, OP_RD, OP_RD, OP_RD);
        3'd2:    e = mk_elem(1'b0, 1'b0, 2'd0, OP_W1, OP_RD, OP_RD, OP_RD);
        default: e = mk_elem(1'b1, 1'b0, 2'd0, OP_RD, OP_RD, OP_RD, OP_RD);
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/mbist_datagen.sv
module mbist_datagen #(
  parameter int DATA_W = 8
) (
  input  logic              addr_lsb,
  input  logic              chk_mode,
  input  logic              pol,
  output logic [DATA_W-1:0] word
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i % 2 == 1) begin : g_odd
      assign word[i] = (chk_mode & ~addr_lsb) ^ pol;
    end else begin : g_even
      assign word[i] = (chk_mode & addr_lsb) ^ pol;
    end
  end
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int AW     = 4,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_exp,
  input  logic [AW-1:0]     in_addr,
  input  logic [DATA_W-1:0] rdata,
  output logic              pend,
  output logic              fail,
  output logic [AW-1:0]     fail_addr
);
  logic [RD_LAT-1:0] vld_p;
  logic [DATA_W-1:0] exp_p  [RD_LAT];
  logic [AW-1:0]     addr_p [RD_LAT];
  logic              mismatch;

  for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_p[g]  <= 1'b0;
        exp_p[g]  <= '0;
        addr_p[g] <= '0;
      end else if (g == 0) begin
        vld_p[g]  <= in_vld;
        exp_p[g]  <= in_exp;
        addr_p[g] <= in_addr;
      end else begin
        vld_p[g]  <= vld_p[(g == 0) ? 0 : g-1];
        exp_p[g]  <= exp_p[(g == 0) ? 0 : g-1];
        addr_p[g] <= addr_p[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign pend     = |vld_p;
  assign mismatch = vld_p[RD_LAT-1] && (rdata != exp_p[RD_LAT-1]);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_p[RD_LAT-1];
    end
  end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    algo_sel,
  input  logic          drained,
  output logic          start_acc,
  output logic          busy,
  output logic          done,
  output logic          op_vld,
  output logic          op_we,
  output logic [AW-1:0] op_addr,
  output logic          op_pol,
  output logic          chk_mode
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_e;

  localparam logic [AW-1:0] ADDR_MAX = AW'(DEPTH - 1);

  state_e     state_q;
  logic [1:0] algo_q;
  logic [2:0] elem_q;
  logic [1:0] opi_q;
  logic [AW-1:0] addr_q;
  logic       pol_elem_q, pol_q;
  logic       busy_q, done_q;

  elem_t desc, desc_nx;
  op_t   op;
  logic  pol_new, last_op, last_addr;

  always_comb begin
    desc      = elem_lookup(algo_q, elem_q);
    desc_nx   = elem_lookup(algo_q, 3'(elem_q + 3'd1));
    op        = desc.ops[opi_q];
    case (op)
      OP_WC:   pol_new = ~pol_q;
      OP_W0:   pol_new = 1'b0;
      OP_W1:   pol_new = 1'b1;
      default: pol_new = pol_q;
    endcase
    last_op   = (opi_q == desc.last_op);
    last_addr = desc.down ? (addr_q == '0) : (addr_q == ADDR_MAX);
  end

  assign start_acc = start && !busy_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign op_vld    = (state_q == S_RUN);
  assign op_we     = (op != OP_RD);
  assign op_addr   = addr_q;
  assign op_pol    = (op == OP_RD) ? pol_q : pol_new;
  assign chk_mode  = (algo_q == ALG_CHECKER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      algo_q     <= '0;
      elem_q     <= '0;
      opi_q      <= '0;
      addr_q     <= '0;
      pol_elem_q <= 1'b0;
      pol_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start) begin
            state_q    <= S_RUN;
            busy_q     <= 1'b1;
            done_q     <= 1'b0;
            algo_q     <= algo_sel;
            elem_q     <= '0;
            opi_q      <= '0;
            addr_q     <= '0;
            pol_elem_q <= 1'b0;
            pol_q      <= 1'b0;
          end
        end
        S_RUN: begin
          if (!last_op) begin
            opi_q <= 2'(opi_q + 2'd1);
            pol_q <= pol_new;
          end else begin
            opi_q <= '0;
            if (!last_addr) begin
              addr_q <= desc.down ? AW'(addr_q - 1'b1) : AW'(addr_q + 1'b1);
              pol_q  <= pol_elem_q;
            end else begin
              pol_elem_q <= pol_new;
              pol_q      <= pol_new;
              if (desc.fin) begin
                state_q <= S_DRAIN;
              end else begin
                elem_q <= 3'(elem_q + 3'd1);
                addr_q <= desc_nx.down ? ADDR_MAX : '0;
              end
            end
          end
        end
        default: begin
          if (drained) begin
            state_q <= S_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mbist_march.sv
module mbist_march #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        algo_sel,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [AW-1:0]     fail_addr
);
  logic              start_acc, drained;
  logic              op_vld, op_we, op_pol, chk_mode;
  logic [AW-1:0]     op_addr;
  logic [DATA_W-1:0] word;
  logic              chk_vld;
  logic [DATA_W-1:0] chk_exp;
  logic              cmp_pend, cmp_fail;

  mbist_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .algo_sel(algo_sel), .drained(drained),
    .start_acc(start_acc), .busy(busy), .done(done),
    .op_vld(op_vld), .op_we(op_we), .op_addr(op_addr), .op_pol(op_pol),
    .chk_mode(chk_mode)
  );

  mbist_datagen #(.DATA_W(DATA_W)) u_gen (
    .addr_lsb(op_addr[0]), .chk_mode(chk_mode), .pol(op_pol), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      chk_vld   <= 1'b0;
      chk_exp   <= '0;
    end else begin
      mem_en    <= op_vld;
      mem_we    <= op_vld && op_we;
      mem_addr  <= op_vld ? op_addr : '0;
      mem_wdata <= (op_vld && op_we) ? word : '0;
      chk_vld   <= op_vld && !op_we;
      chk_exp   <= word;
    end
  end

  mbist_cmp #(.AW(AW), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_cmp (
    .clk(clk), .rst(rst), .clr(start_acc),
    .in_vld(chk_vld), .in_exp(chk_exp), .in_addr(mem_addr), .rdata(mem_rdata),
    .pend(cmp_pend), .fail(cmp_fail), .fail_addr(fail_addr)
  );

  assign drained = !cmp_pend && !mem_en;
  assign pass    = done && !cmp_fail;
endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_en,
  input logic          mem_we,
  input logic          start_acc,
  input logic          fail_q,
  input logic [AW-1:0] fail_addr
);
  a_r10_we_needs_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);

  a_r10_bus_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_done_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !start_acc) |=> fail_q);

  a_r7_addr_held: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !start_acc) |=> $stable(fail_addr));
endmodule

bind mbist_march mbist_march_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_en(mem_en),
  .mem_we(mem_we), .start_acc(start_acc), .fail_q(cmp_fail),
  .fail_addr(fail_addr)
);

// File: tb/sim_mbist_march.sv
module sim_mbist_march;
  localparam int D   = 16;
  localparam int DW  = 8;
  localparam int LAT = 2;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] algo_sel = 2'd0;
  logic mem_en, mem_we, busy, done, pass;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mbist_march #(.DEPTH(D), .DATA_W(DW), .RD_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .start(start), .algo_sel(algo_sel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
  );

  // memory model with stuck-at faults on up to two addresses
  logic [DW-1:0] mem [D];
  logic [DW-1:0] rpipe [LAT];
  logic fa_en = 1'b0, fb_en = 1'b0;
  logic [AW-1:0] fa_addr = '0, fb_addr = '0;
  logic [DW-1:0] sa0 = '0, sa1 = '0;

  function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] raw);
    if ((fa_en && a == fa_addr) || (fb_en && a == fb_addr)) return (raw | sa1) & ~sa0;
    return raw;
  endfunction

  always_ff @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    rpipe[0] <= faulty(mem_addr, mem[mem_addr]);
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
  end
  assign mem_rdata = rpipe[LAT-1];

  // capture of bus operations
  logic          got_we [$];
  logic [AW-1:0] got_ad [$];
  logic [DW-1:0] got_dt [$];
  always @(negedge clk) begin
    if (mem_en) begin
      got_we.push_back(mem_we);
      got_ad.push_back(mem_addr);
      got_dt.push_back(mem_wdata);
    end
  end

  // expected operation list
  logic          ex_we [$];
  logic [AW-1:0] ex_ad [$];
  logic [DW-1:0] ex_dt [$];

  task automatic push(input logic we, input int a, input logic [DW-1:0] d);
    ex_we.push_back(we);
    ex_ad.push_back(AW'(a));
    ex_dt.push_back(d);
  endtask

  function automatic logic [DW-1:0] cbw(input int a, input logic inv);
    logic [DW-1:0] w;
    w = (a % 2 == 0) ? 8'hAA : 8'h55;
    return inv ? ~w : w;
  endfunction

  task automatic build(input logic [1:0] alg);
    ex_we.delete(); ex_ad.delete(); ex_dt.delete();
    if (alg == 2'd1) begin
      for (int a = 0; a < D; a++) push(1, a, 8'h00);
      for (int a = 0; a < D; a++) begin push(0, a, 8'h00); push(1, a, 8'hFF); end
      for (int a = 0; a < D; a++) push(0, a, 8'hFF);
      for (int a = 0; a < D; a++) begin
        push(0, a, 8'hFF); push(1, a, 8'h00); push(0, a, 8'h00); push(1, a, 8'hFF);
      end
      for (int a = D-1; a >= 0; a--) begin push(0, a, 8'hFF); push(1, a, 8'h00); end
      for (int a = D-1; a >= 0; a--) begin
        push(0, a, 8'h00); push(1, a, 8'hFF); push(0, a, 8'hFF); push(1, a, 8'h00);
      end
      for (int a = D-1; a >= 0; a--) push(0, a, 8'h00);
    end else begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < D; a++)
          push(1, a, (alg == 2'd0) ? cbw(a, p[0]) : {DW{p[0]}});
        for (int a = 0; a < D; a++)
          push(0, a, (alg == 2'd0) ? cbw(a, p[0]) : {DW{p[0]}});
      end
    end
  endtask

  // first failing read address predicted from the op list and fault model
  task automatic predict(output logic fails, output logic [AW-1:0] faddr);
    logic [DW-1:0] sh [D];
    fails = 1'b0; faddr = '0;
    for (int i = 0; i < D; i++) sh[i] = '0;
    for (int i = 0; i < ex_we.size(); i++) begin
      if (ex_we[i]) sh[ex_ad[i]] = ex_dt[i];
      else if (!fails && faulty(ex_ad[i], sh[ex_ad[i]]) != ex_dt[i]) begin
        fails = 1'b1; faddr = ex_ad[i];
      end
    end
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [1:0] alg);
    @(negedge clk); algo_sel = alg; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input logic noisy);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      if (noisy && (n % 37 == 5)) begin start = 1'b1; algo_sel = 2'd0; end
      else start = 1'b0;
    end
    start = 1'b0;
    if (!done) check(1'b0, "R9 watchdog on done", 0, 1);
  endtask

  task automatic compare_stream(input string req);
    int bad = -1;
    if (got_we.size() == ex_we.size()) begin
      for (int i = 0; i < ex_we.size(); i++)
        if (bad < 0 && (got_we[i] != ex_we[i] || got_ad[i] != ex_ad[i] ||
            (ex_we[i] && got_dt[i] != ex_dt[i]))) bad = i;
    end
    check(got_we.size() == ex_we.size(), {req, " op count"}, got_we.size(), ex_we.size());
    check(bad < 0, {req, " op stream first bad index"}, bad, -1);
  endtask

  task automatic run_algo(input logic [1:0] alg, input logic noisy, input string req);
    logic ef; logic [AW-1:0] efa;
    build(alg);
    predict(ef, efa);
    got_we.delete(); got_ad.delete(); got_dt.delete();
    pulse_start(alg);
    wait_done(noisy);
    compare_stream(req);
    check(pass == !ef, {req, " pass"}, pass, !ef);
    if (ef) check(fail_addr == efa, {req, " R7 first fail address"}, fail_addr, efa);
    check(!busy, {req, " R9 busy low at done"}, busy, 0);
  endtask

  task automatic t_reset;
    check(!busy && !done && !pass, "R1 status after reset", {busy, done, pass}, 0);
    check(!mem_en && !mem_we, "R1 memory controls after reset", {mem_en, mem_we}, 0);
  endtask

  task automatic t_clean;
    fa_en = 0; fb_en = 0;
    run_algo(2'd0, 1'b0, "R3 R6 checkerboard");
    run_algo(2'd1, 1'b0, "R4 R6 march");
    run_algo(2'd2, 1'b0, "R5 solid code2");
    run_algo(2'd3, 1'b0, "R5 solid code3");
  endtask

  task automatic t_two_faults;
    fa_en = 1; fa_addr = 4'd3; fb_en = 1; fb_addr = 4'd10; sa1 = 8'h01; sa0 = 8'h00;
    run_algo(2'd0, 1'b0, "R7 R8 checkerboard two faults");
    check(fail_addr == 4'd10, "R7 first-in-time address kept", fail_addr, 10);
    run_algo(2'd1, 1'b0, "R8 march with fault");
    fa_en = 0; fb_en = 0; sa1 = 8'h00;
    run_algo(2'd0, 1'b0, "R9 R6 clean run after failing run");
  endtask

  task automatic t_last_read;
    fa_en = 1; fa_addr = 4'(D-1); fb_en = 0; sa0 = 8'h80; sa1 = 8'h00;
    run_algo(2'd2, 1'b0, "R11 last read mismatch");
    check(!pass && fail_addr == 4'(D-1), "R11 reported at done", fail_addr, D-1);
    fa_en = 0; sa0 = 8'h00;
  endtask

  task automatic t_busy_start;
    run_algo(2'd1, 1'b1, "R2 start during run ignored");
  endtask

  task automatic t_done_hold;
    repeat (10) @(negedge clk);
    check(done && !busy, "R9 done held", done, 1);
    check(!mem_en && !mem_we, "R10 bus quiet after done", mem_en, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL R9 global watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_done_hold();
    t_two_faults();
    t_last_read();
    t_busy_start();
    t_done_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule